// File: doc/BRIEF.md
# Modified-Line Cache Walk Flusher

This controller performs the one-time flush that moves a tile from directory coherence to shared-cache coherence. After the tile is halted and a start command arrives, it walks every line of the local L2 tag/state array in ascending index order. A line in modified state whose home core, as reported by a TLB port, is another tile is sent there as a cache-to-cache transfer and invalidated locally. Every other line stays where it is.

While the walk and the drain that follows it are running, the block also accepts lines that other tiles forward to this one. It installs each line as modified at its direct-mapped index. If the displaced victim was modified, the victim is forwarded to its own home tile, or written back to memory when this tile is that home. Forwarding can therefore cascade across tiles. A counter tracks transfers that the network has accepted but whose delivery has not yet been confirmed. The mode register changes to shared-cache mode only when the local walk is over, that counter is zero, no forwarded line is waiting at the input and the rest of the system reports that it is idle.

Top module: `mline_flush_ctrl`

## Requirements
- R1: Out of reset, `mode_shared_o`, `busy_o`, `xfer_valid_o`, `wb_valid_o`, `in_ready_o` and `local_idle_o` are all 0, which is directory mode.
- R2: `start_i` takes effect only in a cycle where `halted_i` is 1 and the mode is still directory. At any other time it is ignored and `busy_o` stays 0, so the flush happens at most once between resets.
- R3: The walk reads indices 0 to NUM_LINES-1 in ascending order. A line address selects its index through its low log2(NUM_LINES) bits. Line states are encoded as invalid = 0, clean = 1 and modified = 2. The home core comes from `tlb_home_i` for the address on `tlb_tag_o`.
- R4: A walked line that is modified and whose home is not LOCAL_CORE is offered on the transfer port with its address and home as the destination, and is rewritten as invalid. The transfer destination never equals LOCAL_CORE.
- R5: Clean lines, invalid lines and modified lines whose home is LOCAL_CORE are left unchanged by the walk.
- R6: A pending transfer holds `xfer_valid_o`, its address and its destination stable until `xfer_ack_i`. The walk does not advance while a transfer is pending.
- R7: `in_ready_o` is 1 only during the walk and the drain. An accepted incoming line is written as modified at its index, and acceptance takes precedence over the next walk step.
- R8: A modified victim displaced by an incoming line whose home is another tile is forwarded on the transfer port to that home.
- R9: A modified victim whose home is LOCAL_CORE is offered on the write-back port, held stable until `wb_ack_i`. A clean or invalid victim is dropped without any request.
- R10: Each `xfer_ack_i` handshake adds one outstanding transfer and each `xfer_cmp_i` pulse removes one. During the drain, `local_idle_o` is 1 exactly when none are outstanding. The mode switches only when this is so, `peers_idle_i` is 1 and `in_valid_i` is 0.
- R11: On completion `mode_shared_o` becomes 1 one cycle after the conditions of R10 hold, and `busy_o` falls. The mode stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halted_i | input | 1 | Application execution is halted |
| start_i | input | 1 | System-wide flush command |
| peers_idle_i | input | 1 | All other tiles walked and idle |
| arr_idx_o | output | IDX_W | Tag/state array index |
| arr_tag_i | input | ADDR_W | Line address stored at `arr_idx_o` |
| arr_st_i | input | 2 | Line state at `arr_idx_o` |
| arr_we_o | output | 1 | Array write enable |
| arr_wtag_o | output | ADDR_W | Line address to write |
| arr_wst_o | output | 2 | Line state to write |
| tlb_tag_o | output | ADDR_W | Address to translate |
| tlb_home_i | input | CORE_W | Home core of `tlb_tag_o` |
| xfer_valid_o | output | 1 | Cache-to-cache transfer request |
| xfer_tag_o | output | ADDR_W | Transferred line address |
| xfer_dest_o | output | CORE_W | Destination core |
| xfer_ack_i | input | 1 | Network accepted the transfer |
| xfer_cmp_i | input | 1 | One earlier transfer was installed remotely |
| wb_valid_o | output | 1 | Memory write-back request |
| wb_tag_o | output | ADDR_W | Written-back line address |
| wb_ack_i | input | 1 | Memory accepted the write-back |
| in_valid_i | input | 1 | Forwarded line arriving |
| in_tag_i | input | ADDR_W | Address of arriving line |
| in_ready_o | output | 1 | Arriving line is accepted this cycle |
| busy_o | output | 1 | Flush in progress |
| local_idle_o | output | 1 | Walk done and no transfer outstanding |
| mode_shared_o | output | 1 | 1 = shared-cache mode, 0 = directory mode |

## Verification
The bench places modified lines with remote homes at the first and last index. A walker with an off-by-one bound would miss one of them or transfer them in the wrong order. Modified lines with a local home sit next to clean and invalid lines, which exposes a design that moves lines it should leave alone. Acknowledgments are delayed, so a design that drops or changes a transfer before the handshake, or keeps walking, shows up as a mismatch against the expected transfer sequence. Incoming lines displace a remote-home modified victim, a local-home modified victim and an invalid victim. A design that writes back everything, or forwards nothing, yields the wrong request lists or a wrong final array. The mode switch is held back first by unconfirmed transfers and then by a non-idle system, which catches any design that switches early. A second start after the switch checks that the flush runs only once.

// File: rtl/flw_pkg.sv
// Shared types for the modified-line flush controller.
// Assumes a 2-bit line state encoding fixed by the array interface.
package flw_pkg;

    typedef enum logic [1:0] {
        ST_INV   = 2'd0,
        ST_CLEAN = 2'd1,
        ST_MOD   = 2'd2
    } line_st_t;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_SCAN  = 3'd1,
        FS_SEND  = 3'd2,
        FS_WB    = 3'd3,
        FS_DRAIN = 3'd4
    } flw_state_t;

endpackage

// File: rtl/flw_inflight.sv
// Counter of transfers accepted by the network but not yet confirmed
// installed at their destination. Assumes a confirmation never arrives
// without a matching earlier acceptance.
module flw_inflight #(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Track outstanding transfers; simultaneous inc and dec cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |-> (cnt_q != '0));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |-> (cnt_q != CNT_MAX));

endmodule

// File: rtl/flw_route.sv
// Decides what happens to a line given its state and home core.
// In walk use only remote modified lines move; in victim use a local
// modified line goes to memory instead. Purely combinational.
module flw_route
    import flw_pkg::*;
#(
    parameter int CORE_W     = 4,
    parameter int LOCAL_CORE = 0
) (
    input  line_st_t           st_i,
    input  logic [CORE_W-1:0]  home_i,
    input  logic               victim_i,
    output logic               fwd_o,
    output logic               wb_o
);
    localparam logic [CORE_W-1:0] LOCAL_ID = CORE_W'(LOCAL_CORE);

    logic is_mod;
    logic remote;

    // Classify the line and pick its destination.
    always_comb begin
        is_mod = (st_i == ST_MOD);
        remote = (home_i != LOCAL_ID);
        fwd_o  = is_mod && remote;
        wb_o   = is_mod && !remote && victim_i;
    end

endmodule

// File: rtl/mline_flush_ctrl.sv
// Walks the local L2 tag/state array after a halt and start command and
// sends modified remote-home lines to their home tile. It also installs
// lines forwarded by other tiles and forwards or writes back modified
// victims. The mode flips to shared-cache when walk, in-flight transfers
// and peers are all quiet. Assumes a combinational array read and TLB
// lookup, and a direct-mapped array indexed by low address bits.
module mline_flush_ctrl
    import flw_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int ADDR_W     = 12,
    parameter int CORE_W     = 4,
    parameter int LOCAL_CORE = 3,
    parameter int CNT_W      = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         halted_i,
    input  logic                         start_i,
    input  logic                         peers_idle_i,
    output logic [$clog2(NUM_LINES)-1:0] arr_idx_o,
    input  logic [ADDR_W-1:0]            arr_tag_i,
    input  logic [1:0]                   arr_st_i,
    output logic                         arr_we_o,
    output logic [ADDR_W-1:0]            arr_wtag_o,
    output logic [1:0]                   arr_wst_o,
    output logic [ADDR_W-1:0]            tlb_tag_o,
    input  logic [CORE_W-1:0]            tlb_home_i,
    output logic                         xfer_valid_o,
    output logic [ADDR_W-1:0]            xfer_tag_o,
    output logic [CORE_W-1:0]            xfer_dest_o,
    input  logic                         xfer_ack_i,
    input  logic                         xfer_cmp_i,
    output logic                         wb_valid_o,
    output logic [ADDR_W-1:0]            wb_tag_o,
    input  logic                         wb_ack_i,
    input  logic                         in_valid_i,
    input  logic [ADDR_W-1:0]            in_tag_i,
    output logic                         in_ready_o,
    output logic                         busy_o,
    output logic                         local_idle_o,
    output logic                         mode_shared_o
);
    localparam int                IDX_W    = $clog2(NUM_LINES);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_LINES - 1);
    localparam logic [CORE_W-1:0] LOCAL_ID = CORE_W'(LOCAL_CORE);

    flw_state_t        state_q;
    flw_state_t        resume_st;
    logic [IDX_W-1:0]  idx_q;
    logic              walked_q;
    logic [ADDR_W-1:0] hold_tag_q;
    logic [CORE_W-1:0] hold_home_q;
    logic              mode_q;
    logic              accept;
    logic              fwd;
    logic              wb;
    logic              scan_move;
    logic              ctr_zero;
    logic              finish;

    // Route decision for the line currently on the array read port.
    flw_route #(.CORE_W(CORE_W), .LOCAL_CORE(LOCAL_CORE)) u_route (
        .st_i     (line_st_t'(arr_st_i)),
        .home_i   (tlb_home_i),
        .victim_i (accept),
        .fwd_o    (fwd),
        .wb_o     (wb)
    );

    // Outstanding transfer tracking for global completion.
    flw_inflight #(.CNT_W(CNT_W)) u_inflight (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (xfer_valid_o && xfer_ack_i),
        .dec_i  (xfer_cmp_i),
        .zero_o (ctr_zero)
    );

    // Array port steering: incoming installs win over the walk step.
    always_comb begin
        in_ready_o = (state_q == FS_SCAN) || (state_q == FS_DRAIN);
        accept     = in_ready_o && in_valid_i;
        arr_idx_o  = accept ? in_tag_i[IDX_W-1:0] : idx_q;
        tlb_tag_o  = arr_tag_i;
        scan_move  = (state_q == FS_SCAN) && !accept && fwd;
        arr_we_o   = accept || scan_move;
        arr_wtag_o = accept ? in_tag_i : arr_tag_i;
        arr_wst_o  = accept ? ST_MOD : ST_INV;
    end

    // Request ports, status and completion condition.
    always_comb begin
        xfer_valid_o  = (state_q == FS_SEND);
        xfer_tag_o    = hold_tag_q;
        xfer_dest_o   = hold_home_q;
        wb_valid_o    = (state_q == FS_WB);
        wb_tag_o      = hold_tag_q;
        busy_o        = (state_q != FS_IDLE);
        local_idle_o  = (state_q == FS_DRAIN) && ctr_zero;
        finish        = local_idle_o && !in_valid_i && peers_idle_i;
        mode_shared_o = mode_q;
        resume_st     = walked_q ? FS_DRAIN : FS_SCAN;
    end

    // Walk sequencer, request holding registers and mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FS_IDLE;
            idx_q       <= '0;
            walked_q    <= 1'b0;
            hold_tag_q  <= '0;
            hold_home_q <= '0;
            mode_q      <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (start_i && halted_i && !mode_q) begin
                        state_q  <= FS_SCAN;
                        idx_q    <= '0;
                        walked_q <= 1'b0;
                    end
                end
                FS_SCAN, FS_DRAIN: begin
                    hold_tag_q  <= arr_tag_i;
                    hold_home_q <= tlb_home_i;
                    if (accept) begin
                        if (fwd) begin
                            state_q <= FS_SEND;
                        end else if (wb) begin
                            state_q <= FS_WB;
                        end
                    end else if (state_q == FS_SCAN) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            walked_q <= 1'b1;
                        end
                        if (fwd) begin
                            state_q <= FS_SEND;
                        end else if (idx_q == LAST_IDX) begin
                            state_q <= FS_DRAIN;
                        end
                    end else if (finish) begin
                        mode_q  <= 1'b1;
                        state_q <= FS_IDLE;
                    end
                end
                FS_SEND: begin
                    if (xfer_ack_i) begin
                        state_q <= resume_st;
                    end
                end
                FS_WB: begin
                    if (wb_ack_i) begin
                        state_q <= resume_st;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // R6
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !xfer_ack_i) |=>
        (xfer_valid_o && $stable(xfer_tag_o) && $stable(xfer_dest_o)));

    // R9
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !wb_ack_i) |=> (wb_valid_o && $stable(wb_tag_o)));

    // R4
    xfer_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o |-> (xfer_dest_o != LOCAL_ID));

    // R11
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_shared_o |=> mode_shared_o);

    // R10
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_shared_o) |-> $past(peers_idle_i && local_idle_o && !in_valid_i));

    // R2
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !halted_i) |=> !busy_o);

    // R7
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_valid_o && wb_valid_o) && !(in_ready_o && (xfer_valid_o || wb_valid_o)));

endmodule

// File: tb/mline_flush_ctrl_tb.sv
`timescale 1ns/1ps
module mline_flush_ctrl_tb;
    localparam int N      = 16;
    localparam int AW     = 12;
    localparam int CW     = 4;
    localparam int LOCAL  = 3;
    localparam int XDLY   = 3;
    localparam int WDLY   = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          halted_i, start_i, peers_idle_i;
    logic [3:0]    arr_idx_o;
    logic [AW-1:0] arr_tag_i;
    logic [1:0]    arr_st_i;
    logic          arr_we_o;
    logic [AW-1:0] arr_wtag_o;
    logic [1:0]    arr_wst_o;
    logic [AW-1:0] tlb_tag_o;
    logic [CW-1:0] tlb_home_i;
    logic          xfer_valid_o, xfer_ack_i, xfer_cmp_i;
    logic [AW-1:0] xfer_tag_o;
    logic [CW-1:0] xfer_dest_o;
    logic          wb_valid_o, wb_ack_i;
    logic [AW-1:0] wb_tag_o;
    logic          in_valid_i, in_ready_o;
    logic [AW-1:0] in_tag_i;
    logic          busy_o, local_idle_o, mode_shared_o;

    int checks = 0;
    int errors = 0;

    // Behavioural array contents, expected final contents, request queues.
    logic [AW-1:0] m_tag [N];
    logic [1:0]    m_st  [N];
    logic [AW-1:0] e_tag [N];
    logic [1:0]    e_st  [N];
    logic [AW-1:0] exp_x_tag[$];
    logic [CW-1:0] exp_x_dst[$];
    logic [AW-1:0] exp_w_tag[$];

    always #4 clk = ~clk;

    mline_flush_ctrl #(.NUM_LINES(N), .ADDR_W(AW), .CORE_W(CW),
                       .LOCAL_CORE(LOCAL), .CNT_W(6)) u_dut (.*);

    function automatic logic [AW-1:0] mk(input int hi, input int home, input int idx);
        return {4'(hi), 4'(home), 4'(idx)};
    endfunction

    assign arr_tag_i  = m_tag[arr_idx_o];
    assign arr_st_i   = m_st[arr_idx_o];
    assign tlb_home_i = tlb_tag_o[7:4];

    always @(posedge clk) begin
        if (arr_we_o) begin
            m_tag[arr_idx_o] <= arr_wtag_o;
            m_st[arr_idx_o]  <= arr_wst_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Transfer and write-back responders with delayed acknowledgments.
    int xcnt = 0, wcnt = 0;
    logic [AW-1:0] x_lat_tag, w_lat_tag;
    logic [CW-1:0] x_lat_dst;
    always @(negedge clk) begin
        if (!rst_n) begin
            xfer_ack_i = 1'b0; wb_ack_i = 1'b0; xcnt = 0; wcnt = 0;
        end else begin
            if (xfer_ack_i) begin
                xfer_ack_i = 1'b0; xcnt = 0;
            end else if (xfer_valid_o) begin
                if (xcnt > 0) // R6 request held while unacknowledged
                    chk(xfer_tag_o == x_lat_tag && xfer_dest_o == x_lat_dst,
                        "R6 xfer stable", int'(xfer_tag_o), int'(x_lat_tag));
                x_lat_tag = xfer_tag_o; x_lat_dst = xfer_dest_o;
                xcnt++;
                if (xcnt == XDLY) begin
                    if (exp_x_tag.size() == 0) begin
                        chk(1'b0, "R4/R8 unexpected xfer", int'(xfer_tag_o), 0);
                    end else begin
                        chk(xfer_tag_o == exp_x_tag[0], "R4/R8 xfer tag",
                            int'(xfer_tag_o), int'(exp_x_tag[0]));
                        chk(xfer_dest_o == exp_x_dst[0], "R4/R8 xfer dest",
                            int'(xfer_dest_o), int'(exp_x_dst[0]));
                        void'(exp_x_tag.pop_front());
                        void'(exp_x_dst.pop_front());
                    end
                    xfer_ack_i = 1'b1;
                end
            end
            if (wb_ack_i) begin
                wb_ack_i = 1'b0; wcnt = 0;
            end else if (wb_valid_o) begin
                if (wcnt > 0)
                    chk(wb_tag_o == w_lat_tag, "R9 wb stable", int'(wb_tag_o), int'(w_lat_tag));
                w_lat_tag = wb_tag_o;
                wcnt++;
                if (wcnt == WDLY) begin
                    if (exp_w_tag.size() == 0) begin
                        chk(1'b0, "R9 unexpected wb", int'(wb_tag_o), 0);
                    end else begin
                        chk(wb_tag_o == exp_w_tag[0], "R9 wb tag",
                            int'(wb_tag_o), int'(exp_w_tag[0]));
                        void'(exp_w_tag.pop_front());
                    end
                    wb_ack_i = 1'b1;
                end
            end
        end
    end

    task automatic send_in(input logic [AW-1:0] t);
        @(negedge clk);
        in_valid_i = 1'b1; in_tag_i = t;
        forever begin
            if (in_ready_o) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_cmp();
        @(negedge clk); xfer_cmp_i = 1'b1;
        @(negedge clk); xfer_cmp_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_array(input string req);
        for (int i = 0; i < N; i++) begin
            chk(m_tag[i] == e_tag[i] && m_st[i] == e_st[i], req,
                int'({m_st[i], m_tag[i]}), int'({e_st[i], e_tag[i]}));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        halted_i = 0; start_i = 0; peers_idle_i = 0; xfer_cmp_i = 0;
        in_valid_i = 0; in_tag_i = '0; xfer_ack_i = 0; wb_ack_i = 0;
        rst_n = 0;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = mk(1, LOCAL, i); m_st[i] = 2'd1;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mode_shared_o && !busy_o, "R1 mode/busy", int'({mode_shared_o, busy_o}), 0);
        chk(!xfer_valid_o && !wb_valid_o && !in_ready_o && !local_idle_o, "R1 requests",
            int'({xfer_valid_o, wb_valid_o, in_ready_o, local_idle_o}), 0);
        rst_n = 1'b1;

        // ---- Scenario A: plain walk ----
        for (int i = 0; i < N; i++) begin
            m_tag[i] = mk(2, LOCAL, i); m_st[i] = 2'd1;
        end
        m_tag[0]  = mk(2, 5, 0);  m_st[0]  = 2'd2;
        m_tag[1]  = mk(2, 5, 1);  m_st[1]  = 2'd1;
        m_tag[2]  = mk(2, 3, 2);  m_st[2]  = 2'd2;
        m_tag[3]  = mk(2, 8, 3);  m_st[3]  = 2'd0;
        m_tag[4]  = mk(2, 9, 4);  m_st[4]  = 2'd2;
        m_tag[15] = mk(2, 0, 15); m_st[15] = 2'd2;
        for (int i = 0; i < N; i++) begin
            e_tag[i] = m_tag[i]; e_st[i] = m_st[i];
        end
        e_st[0] = 2'd0; e_st[4] = 2'd0; e_st[15] = 2'd0; // R4 moved lines invalid
        exp_x_tag.push_back(mk(2, 5, 0));  exp_x_dst.push_back(4'd5);
        exp_x_tag.push_back(mk(2, 9, 4));  exp_x_dst.push_back(4'd9);
        exp_x_tag.push_back(mk(2, 0, 15)); exp_x_dst.push_back(4'd0);

        // R2 start while not halted is ignored
        pulse_start();
        @(negedge clk);
        chk(!busy_o, "R2 start without halt", int'(busy_o), 0);

        halted_i = 1'b1; peers_idle_i = 1'b1;
        pulse_start();
        chk(busy_o, "R2 start accepted", int'(busy_o), 1);
        repeat (120) @(negedge clk);
        // R10 three transfers unconfirmed: no switch yet
        chk(!mode_shared_o && busy_o && !local_idle_o, "R10 wait for confirmations",
            int'({mode_shared_o, busy_o, local_idle_o}), 2);
        chk(exp_x_tag.size() == 0, "R3 all transfers seen", exp_x_tag.size(), 0);
        check_array("R5 array after walk");
        pulse_cmp(); pulse_cmp();
        @(negedge clk);
        chk(!mode_shared_o, "R10 one still outstanding", int'(mode_shared_o), 0);
        pulse_cmp();
        repeat (2) @(negedge clk);
        chk(mode_shared_o && !busy_o, "R11 mode set", int'({mode_shared_o, busy_o}), 2);
        // R2 second start ignored, R11 mode sticky
        pulse_start();
        repeat (2) @(negedge clk);
        chk(!busy_o && mode_shared_o, "R2 second start ignored",
            int'({mode_shared_o, busy_o}), 2);

        // ---- Scenario B: incoming lines and cascaded victims ----
        peers_idle_i = 1'b0;
        do_reset();
        chk(!mode_shared_o, "R11 reset clears mode", int'(mode_shared_o), 0);
        for (int i = 0; i < N; i++) begin
            m_tag[i] = mk(4, (i * 5) % 16, i); m_st[i] = 2'd1;
        end
        m_tag[5] = mk(4, 7, 5); m_st[5] = 2'd2;
        m_tag[6] = mk(4, 3, 6); m_st[6] = 2'd2;
        m_tag[7] = mk(4, 9, 7); m_st[7] = 2'd0;
        for (int i = 0; i < N; i++) begin
            e_tag[i] = m_tag[i]; e_st[i] = m_st[i];
        end
        e_tag[5] = mk(6, 3, 5); e_st[5] = 2'd2;  // R7 installs modified
        e_tag[6] = mk(6, 3, 6); e_st[6] = 2'd2;
        e_tag[7] = mk(6, 3, 7); e_st[7] = 2'd2;
        e_tag[2] = mk(6, 3, 2); e_st[2] = 2'd2;
        exp_x_tag.push_back(mk(4, 7, 5)); exp_x_dst.push_back(4'd7); // R8
        exp_w_tag.push_back(mk(4, 3, 6));                          // R9
        @(negedge clk);
        chk(!in_ready_o, "R7 not ready when idle", int'(in_ready_o), 0);
        pulse_start();
        send_in(mk(6, 3, 5));
        send_in(mk(6, 3, 6));
        send_in(mk(6, 3, 7));
        repeat (60) @(negedge clk);
        chk(in_ready_o && busy_o, "R7 ready during drain", int'({in_ready_o, busy_o}), 3);
        send_in(mk(6, 3, 2));
        repeat (10) @(negedge clk);
        chk(exp_x_tag.size() == 0, "R8 victim forwarded", exp_x_tag.size(), 0);
        chk(exp_w_tag.size() == 0, "R9 victim written back", exp_w_tag.size(), 0);
        check_array("R7 array after installs");
        pulse_cmp();
        repeat (2) @(negedge clk);
        chk(local_idle_o && !mode_shared_o, "R10 peers busy holds mode",
            int'({local_idle_o, mode_shared_o}), 2);
        peers_idle_i = 1'b1;
        @(negedge clk);
        chk(mode_shared_o && !busy_o, "R11 switch when peers idle",
            int'({mode_shared_o, busy_o}), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule